// File: doc/BRIEF.md
# FSK Byte Framer with Begin-of-Mark Gating

This block sits behind a 1200 baud FSK demodulator in a caller-identity receiver. It turns the demodulated serial stream into asynchronous bytes. Each word has a space start bit, eight data bits sent least significant bit first, and a mark stop bit. The line is oversampled sixteen times per bit. A start bit counts only if the line is still low half a bit after the falling edge, and every later bit is read at its centre.

Alongside the framer, a preamble tracker looks for the alternating channel-seizure pattern. After that pattern it looks for an unbroken run of mark bits, and it then sets a sticky begin-of-mark status. When the mask control is set, bytes are withheld until that status is up, so the seizure pattern never reaches the host. When the mask is clear, the seizure is framed like any other data. Every delivered byte is loaded into the output data register together with a one-cycle interrupt pulse. Turning the receiver off resets the framer and the tracker, and it clears the status.

Top module: `fsk_byte_framer`

## Requirements
- R1: While `rx_en` is 0 the receiver is idle: `byte_irq_o` stays 0 and `data_o` keeps its last value, whatever arrives on `rx_bit`.
- R2: A word (one start bit of 0, eight data bits with bit 0 first, one stop bit of 1) loads the byte into `data_o`, and `byte_irq_o` is 1 for exactly that clock cycle. `data_o` changes on no other cycle.
- R3: A word whose stop bit reads 0 is discarded: no interrupt, and `data_o` is unchanged.
- R4: A low pulse shorter than half a bit period on an idle line is rejected as a false start and produces no byte.
- R5: A line held at mark produces no byte, however long it lasts.
- R6: Channel seizure is recognised after `SEIZE_BITS` (default 8) consecutive bit periods, each differing from the one before. After that, `bom_o` rises once `MARK_BITS` (default 10) consecutive mark bit periods have been seen. Nine marks are not enough. Without seizure, `bom_o` stays 0.
- R7: `bom_o` stays set while the receiver is enabled, and it is 0 from the cycle after `rx_en` falls.
- R8: With `bom_mask_en` = 1, no byte is delivered and no interrupt is raised while `bom_o` is 0.
- R9: With `bom_mask_en` = 0, the seizure pattern 1010... is framed as ordinary data and delivered as bytes of value 0x55.
- R10: After reset `data_o` is 0x00, `byte_irq_o` is 0 and `bom_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; 0 holds framer and tracker cleared |
| bom_mask_en | input | 1 | 1: withhold bytes until begin-of-mark; 0: deliver all framed bytes |
| rx_bit | input | 1 | Demodulated serial bit (1 = mark, 0 = space), asynchronous |
| data_o | output | 8 | Last delivered byte |
| byte_irq_o | output | 1 | One-cycle pulse when a byte is delivered |
| bom_o | output | 1 | Begin-of-mark status |

## Verification
The hardest case is the exact mark-count threshold. It matters both on its own and at the point where the mask releases delivery. Reaching it needs a real seizure pattern followed by a precise number of mark bits, so the bench stops at nine marks and breaks the run with a byte that must be suppressed. In a later run it sends exactly ten marks and samples the status before any further edge arrives. The rejected-start case is reached with a low pulse three oversample ticks wide, placed at a bit boundary. The bench then follows it with a real byte, which must arrive intact.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

    localparam int unsigned WORD_BITS  = 8;
    localparam int unsigned OVERSAMPLE = 16;
    localparam int unsigned MID_TICK   = OVERSAMPLE / 2;
    localparam int unsigned PHASE_W    = $clog2(OVERSAMPLE);
    localparam int unsigned IDX_W      = $clog2(WORD_BITS);

    typedef logic [WORD_BITS-1:0] word_t;
    typedef logic [PHASE_W-1:0]   phase_t;
    typedef logic [IDX_W-1:0]     idx_t;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_STOP
    } fr_state_e;

    // Per-clock view of the sampled line
    typedef struct packed {
        logic tick;    // oversample strobe
        logic level;   // synchronised line level
        logic fall;    // mark-to-space transition seen on this tick
        logic centre;  // estimated bit centre on this tick
    } line_ev_t;

    typedef struct packed {
        logic  valid;
        word_t data;
    } frame_t;

    localparam phase_t PHASE_LAST = phase_t'(OVERSAMPLE - 1);
    localparam phase_t PHASE_MID  = phase_t'(MID_TICK - 1);

    function automatic word_t shift_in_msb(input word_t cur, input logic b);
        return {b, cur[WORD_BITS-1:1]};
    endfunction

endpackage

// File: rtl/fbf_tick_gen.sv
module fbf_tick_gen #(
    parameter int unsigned TICK_DIV = 187
) (
    input  logic clk,
    input  logic clr,
    output logic tick_o
);
    localparam int unsigned CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (clr || tick_o) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (clr)
        tick_o |=> !tick_o)
        else $error("oversample strobe on consecutive cycles");

endmodule

// File: rtl/fbf_line_sampler.sv
module fbf_line_sampler
    import fbf_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     clr,
    input  logic     tick_i,
    input  logic     rx_i,
    output line_ev_t ev_o
);
    logic [SYNC_STAGES-1:0] sync_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (clr) sync_q[0] <= 1'b1;
                    else     sync_q[0] <= rx_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (clr) sync_q[g] <= 1'b1;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    logic   level;
    logic   line_q;
    phase_t ph_q;
    logic   edge_seen;

    assign level     = sync_q[SYNC_STAGES-1];
    assign edge_seen = tick_i && (line_q != level);

    always_ff @(posedge clk) begin
        if (clr) begin
            line_q <= 1'b1;
            ph_q   <= '0;
        end else if (tick_i) begin
            line_q <= level;
            ph_q   <= edge_seen ? '0 : ph_q + 1'b1;
        end
    end

    always_comb begin
        ev_o.tick   = tick_i;
        ev_o.level  = level;
        ev_o.fall   = tick_i && line_q && !level;
        ev_o.centre = tick_i && !edge_seen && (ph_q == PHASE_MID);
    end

endmodule

// File: rtl/fbf_frame_rx.sv
module fbf_frame_rx
    import fbf_pkg::*;
(
    input  logic     clk,
    input  logic     clr,
    input  line_ev_t ev_i,
    output frame_t   fr_o
);
    fr_state_e state_q;
    phase_t    cnt_q;
    idx_t      idx_q;
    word_t     sr_q;
    logic      valid_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            state_q <= FR_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            sr_q    <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            unique case (state_q)
                FR_IDLE: begin
                    if (ev_i.fall) begin
                        state_q <= FR_START;
                        cnt_q   <= '0;
                    end
                end
                FR_START: begin
                    if (ev_i.tick) begin
                        if (cnt_q == PHASE_MID) begin
                            state_q <= ev_i.level ? FR_IDLE : FR_DATA;
                            cnt_q   <= '0;
                            idx_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                FR_DATA: begin
                    if (ev_i.tick) begin
                        if (cnt_q == PHASE_LAST) begin
                            sr_q  <= shift_in_msb(sr_q, ev_i.level);
                            cnt_q <= '0;
                            idx_q <= idx_q + 1'b1;
                            if (idx_q == idx_t'(WORD_BITS - 1)) state_q <= FR_STOP;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                FR_STOP: begin
                    if (ev_i.tick) begin
                        if (cnt_q == PHASE_LAST) begin
                            valid_q <= ev_i.level;
                            state_q <= FR_IDLE;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= FR_IDLE;
            endcase
        end
    end

    assign fr_o.valid = valid_q;
    assign fr_o.data  = sr_q;

    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (clr)
        fr_o.valid |=> !fr_o.valid)
        else $error("frame valid longer than one cycle");

    assert_start_low_R4: assert property (@(posedge clk) disable iff (clr)
        (state_q == FR_DATA && $past(state_q) == FR_START) |-> !$past(ev_i.level))
        else $error("data phase entered without a low mid-start sample");

    assert_valid_after_stop_R3: assert property (@(posedge clk) disable iff (clr)
        fr_o.valid |-> ($past(state_q) == FR_STOP && $past(ev_i.tick)))
        else $error("frame valid without a stop sample");

endmodule

// File: rtl/fbf_preamble_trk.sv
module fbf_preamble_trk
    import fbf_pkg::*;
#(
    parameter int unsigned SEIZE_BITS = 8,
    parameter int unsigned MARK_BITS  = 10
) (
    input  logic     clk,
    input  logic     clr,
    input  line_ev_t ev_i,
    output logic     bom_o
);
    localparam int unsigned AW = $clog2(SEIZE_BITS + 1);
    localparam int unsigned MW = $clog2(MARK_BITS + 1);
    localparam logic [AW-1:0] ALT_LAST  = AW'(SEIZE_BITS - 1);
    localparam logic [MW-1:0] MARK_LAST = MW'(MARK_BITS - 1);

    logic [AW-1:0] alt_q;
    logic [MW-1:0] mark_q;
    logic          last_q;
    logic          seize_q;
    logic          bom_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            alt_q   <= '0;
            mark_q  <= '0;
            last_q  <= 1'b1;
            seize_q <= 1'b0;
            bom_q   <= 1'b0;
        end else if (ev_i.centre) begin
            last_q <= ev_i.level;
            // alternation run
            if (ev_i.level != last_q) begin
                if (alt_q >= ALT_LAST) seize_q <= 1'b1;
                if (alt_q < AW'(SEIZE_BITS)) alt_q <= alt_q + 1'b1;
            end else begin
                alt_q <= '0;
            end
            // mark run
            if (ev_i.level) begin
                if (seize_q && mark_q >= MARK_LAST) bom_q <= 1'b1;
                if (mark_q < MW'(MARK_BITS)) mark_q <= mark_q + 1'b1;
            end else begin
                mark_q <= '0;
            end
        end
    end

    assign bom_o = bom_q;

    assert_bom_cause_R6: assert property (@(posedge clk) disable iff (clr)
        $rose(bom_o) |-> $past(ev_i.centre && ev_i.level && seize_q))
        else $error("begin-of-mark set outside a mark centre after seizure");

    assert_bom_sticky_R7: assert property (@(posedge clk) disable iff (clr)
        bom_o |=> bom_o)
        else $error("begin-of-mark dropped while enabled");

endmodule

// File: rtl/fsk_byte_framer.sv
module fsk_byte_framer
    import fbf_pkg::*;
#(
    parameter int unsigned TICK_DIV    = 187,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned SEIZE_BITS  = 8,
    parameter int unsigned MARK_BITS   = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_en,
    input  logic                 bom_mask_en,
    input  logic                 rx_bit,
    output logic [WORD_BITS-1:0] data_o,
    output logic                 byte_irq_o,
    output logic                 bom_o
);
    logic     clr;
    logic     tick;
    line_ev_t ev;
    frame_t   fr;
    logic     bom;
    logic     deliver;
    word_t    data_q;
    logic     irq_q;

    assign clr = rst || !rx_en;

    fbf_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .clr    (clr),
        .tick_o (tick)
    );

    fbf_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk    (clk),
        .clr    (clr),
        .tick_i (tick),
        .rx_i   (rx_bit),
        .ev_o   (ev)
    );

    fbf_frame_rx u_frame (
        .clk  (clk),
        .clr  (clr),
        .ev_i (ev),
        .fr_o (fr)
    );

    fbf_preamble_trk #(
        .SEIZE_BITS (SEIZE_BITS),
        .MARK_BITS  (MARK_BITS)
    ) u_pre (
        .clk   (clk),
        .clr   (clr),
        .ev_i  (ev),
        .bom_o (bom)
    );

    assign deliver = fr.valid && (!bom_mask_en || bom);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= deliver && rx_en;
            if (deliver && rx_en) data_q <= fr.data;
        end
    end

    assign data_o     = data_q;
    assign byte_irq_o = irq_q;
    assign bom_o      = bom;

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !byte_irq_o)
        else $error("byte interrupt after the receiver was disabled");

    assert_disable_clears_R7: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !bom_o)
        else $error("begin-of-mark still set after disable");

    assert_mask_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (fr.valid && bom_mask_en && !bom_o) |=> !byte_irq_o)
        else $error("byte delivered before begin-of-mark with mask on");

    assert_data_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !byte_irq_o |-> $stable(data_o) || $past(rst))
        else $error("data register changed without an interrupt");

endmodule

// File: tb/sim_fsk_byte_framer.sv
module sim_fsk_byte_framer;
    localparam int DIV      = 2;
    localparam int BIT_CLKS = 16 * DIV;
    localparam int SEIZE    = 8;
    localparam int MARKS    = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_en = 1'b0;
    logic       bom_mask_en = 1'b0;
    logic       rx_bit = 1'b1;
    logic [7:0] data_o;
    logic       byte_irq_o;
    logic       bom_o;

    always #5 clk = ~clk;

    fsk_byte_framer #(
        .TICK_DIV   (DIV),
        .SEIZE_BITS (SEIZE),
        .MARK_BITS  (MARKS)
    ) u0 (
        .clk         (clk),
        .rst         (rst),
        .rx_en       (rx_en),
        .bom_mask_en (bom_mask_en),
        .rx_bit      (rx_bit),
        .data_o      (data_o),
        .byte_irq_o  (byte_irq_o),
        .bom_o       (bom_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    logic [7:0] last_data = 8'h00;

    // bit-level behavioural model
    int         m_fr;
    logic [7:0] m_sh;
    logic       m_prev, m_aprev, m_seize, m_bom;
    int         m_arun, m_mrun;

    task automatic model_reset();
        m_fr = -1; m_sh = 8'h00; m_prev = 1'b1; m_aprev = 1'b1;
        m_seize = 1'b0; m_bom = 1'b0; m_arun = 0; m_mrun = 0;
    endtask

    task automatic model_bit(input logic b);
        if (!rx_en) return;
        if (b) begin
            m_mrun++;
            if (m_seize && m_mrun >= MARKS) m_bom = 1'b1;
        end else m_mrun = 0;
        if (b != m_aprev) begin
            m_arun++;
            if (m_arun >= SEIZE) m_seize = 1'b1;
        end else m_arun = 0;
        m_aprev = b;
        if (m_fr == -1) begin
            if (!b && m_prev) begin m_fr = 0; m_sh = 8'h00; end
        end else if (m_fr < 8) begin
            m_sh[m_fr] = b; m_fr++;
        end else begin
            if (b && (!bom_mask_en || m_bom)) exp_q.push_back(m_sh);
            m_fr = -1;
        end
        m_prev = b;
    endtask

    task automatic chk(input logic ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        model_bit(b);
        rx_bit = b;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_marks(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic send_seizure(input int n);
        for (int i = 0; i < n; i++) send_bit((i % 2) == 0);
    endtask

    task automatic send_byte(input logic [7:0] d, input logic stop);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        send_bit(stop);
    endtask

    task automatic set_enable(input logic en);
        @(negedge clk);
        rx_en = en;
        model_reset();
        repeat (3) @(negedge clk);
    endtask

    // per-clock comparison against the model's expected byte stream
    always @(negedge clk) begin
        if (!rst) begin
            if (byte_irq_o) begin
                if (exp_q.size() == 0)
                    chk(1'b0, "R1/R8", "unexpected byte interrupt", data_o, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(data_o == e, "R2", "delivered byte", data_o, e);
                end
            end else begin
                chk(data_o == last_data, "R2", "data changed without interrupt", data_o, last_data);
            end
            last_data = data_o;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (5) @(negedge clk);
        chk(data_o == 8'h00, "R10", "reset data", data_o, 0);
        chk(byte_irq_o == 1'b0, "R10", "reset irq", byte_irq_o, 0);
        chk(bom_o == 1'b0, "R10", "reset bom", bom_o, 0);
        rst = 1'b0;

        // masked: seizure suppressed, 9 marks short of threshold
        bom_mask_en = 1'b1;
        set_enable(1'b1);
        send_marks(4);
        send_seizure(20);
        send_marks(9);
        chk(bom_o == 1'b0, "R6", "nine marks not enough", bom_o, 0);
        send_byte(8'hA3, 1'b1);
        chk(exp_q.size() == 0 && data_o == 8'h00, "R8", "masked byte held back", data_o, 0);
        send_marks(10);
        chk(bom_o == 1'b1, "R6", "bom after mark run", bom_o, 1);
        send_byte(8'h00, 1'b1);
        send_byte(8'hFF, 1'b1);
        send_byte(8'h5A, 1'b1);
        send_byte(8'h81, 1'b1);
        send_marks(2);
        chk(data_o == 8'h81, "R2", "last byte in register", data_o, 8'h81);
        send_byte(8'h3C, 1'b0);
        send_marks(2);
        chk(data_o == 8'h81, "R3", "bad stop discarded", data_o, 8'h81);
        send_byte(8'hC7, 1'b1);
        send_marks(2);
        chk(exp_q.size() == 0, "R2", "all bytes delivered", exp_q.size(), 0);
        chk(bom_o == 1'b1, "R7", "bom sticky while enabled", bom_o, 1);

        // disabled: status cleared, line ignored
        set_enable(1'b0);
        chk(bom_o == 1'b0, "R7", "bom cleared on disable", bom_o, 0);
        send_marks(2);
        send_byte(8'h6E, 1'b1);
        send_marks(2);
        chk(data_o == 8'hC7, "R1", "disabled ignores line", data_o, 8'hC7);

        // unmasked: long marks, glitch, then a real byte
        bom_mask_en = 1'b0;
        set_enable(1'b1);
        send_marks(40);
        chk(data_o == 8'hC7 && exp_q.size() == 0, "R5", "marks give no byte", data_o, 8'hC7);
        chk(bom_o == 1'b0, "R6", "no seizure no bom", bom_o, 0);
        rx_bit = 1'b0;
        repeat (3 * DIV) @(negedge clk);
        rx_bit = 1'b1;
        repeat (BIT_CLKS - 3 * DIV) @(negedge clk);
        send_marks(2);
        chk(data_o == 8'hC7, "R4", "short low rejected", data_o, 8'hC7);
        send_byte(8'h9D, 1'b1);
        send_marks(2);
        chk(data_o == 8'h9D, "R2", "byte after glitch", data_o, 8'h9D);

        // unmasked seizure passes through; exact mark threshold
        set_enable(1'b0);
        set_enable(1'b1);
        send_marks(3);
        send_seizure(20);
        send_marks(10);
        chk(bom_o == 1'b1, "R6", "bom at exactly ten marks", bom_o, 1);
        chk(data_o == 8'h55 && exp_q.size() == 0, "R9", "seizure bytes delivered", data_o, 8'h55);
        send_byte(8'h12, 1'b1);
        send_byte(8'hE4, 1'b1);
        send_marks(2);
        chk(data_o == 8'hE4, "R2", "post-preamble bytes", data_o, 8'hE4);

        // masked without any seizure: everything held back
        set_enable(1'b0);
        bom_mask_en = 1'b1;
        set_enable(1'b1);
        send_marks(12);
        send_byte(8'h27, 1'b1);
        send_byte(8'hB0, 1'b1);
        send_marks(2);
        chk(bom_o == 1'b0, "R8", "no bom without seizure", bom_o, 0);
        chk(data_o == 8'hE4 && exp_q.size() == 0, "R8", "masked bytes suppressed", data_o, 8'hE4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule